// File: doc/BRIEF.md
# Multicycle Instruction Sequencing Controller

This block is the control unit of a multicycle processor datapath that shares one memory and one ALU across the steps of an instruction. It is a Moore state machine. On each clock it moves from one step to the next and drives the datapath's select and enable lines. The lines it drives are the memory read and write strobes, the instruction-register and PC write enables, the ALU operand selects, the ALU operation class, and the register-file write controls. Every output is decoded from the current state alone. The instruction opcode only steers which state comes next.

Every instruction starts with the same two states. The first fetches the instruction and adds 4 to the PC. The second reads the source registers and computes a possible branch target before the opcode is known. After these two steps the sequence splits by instruction class, so the instruction length depends on the class: a jump or branch-equal takes 3 cycles, a store or register-register ALU operation takes 4 cycles, and a load takes 5 cycles. The opcode comes from the instruction register and is expected to stay stable from the decode state onward.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after `rst` falls, the outputs show the fetch pattern. A reset in the middle of an instruction abandons that instruction.
- R2: The fetch pattern is `pc_wr`=1, `mem_rd`=1, `ir_wr`=1, `alu_b_sel`=01 (constant 4), and every other output at 0. In that pattern `alu_op`=00 (add) and `pc_src`=00 (ALU result).
- R3: The cycle after fetch is decode: `alu_b_sel`=11 (shifted sign-extended offset), `alu_a_reg`=0, `alu_op`=00, all enables 0.
- R4: For a load (opcode 0x23) or a store (opcode 0x2B), the cycle after decode is address formation: `alu_a_reg`=1, `alu_b_sel`=10 (sign-extended offset), `alu_op`=00, all enables 0.
- R5: A load continues with a memory-read cycle (`mem_rd`=1, `mem_addr_alu`=1). It then takes a writeback cycle (`rf_wr`=1, `rf_wdata_mem`=1, `rf_dst_rd`=0) and returns to fetch, for 5 cycles in all.
- R6: A store continues with a memory-write cycle (`mem_wr`=1, `mem_addr_alu`=1) and then returns to fetch, for 4 cycles in all.
- R7: An R-type instruction (opcode 0x00) executes with `alu_a_reg`=1, `alu_b_sel`=00 and `alu_op`=10 (function field). It then writes back with `rf_wr`=1, `rf_dst_rd`=1, `rf_wdata_mem`=0 and returns to fetch, for 4 cycles in all.
- R8: A branch-equal (opcode 0x04) completes in its third cycle with `alu_a_reg`=1, `alu_b_sel`=00, `alu_op`=01 (subtract), `pc_wr_cond`=1 and `pc_src`=01 (stored ALU result). It then returns to fetch.
- R9: A jump (opcode 0x02) completes in its third cycle with `pc_wr`=1 and `pc_src`=10 (jump target), and all else 0. It then returns to fetch.
- R10: An opcode outside the five supported ones sends decode straight back to fetch, giving a 2-cycle sequence. In the address state, an opcode that is neither load nor store also returns to fetch.
- R11: Outputs depend only on the state: an opcode change within a cycle leaves them unchanged, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, forces fetch |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_wr | output | 1 | Unconditional PC write enable |
| pc_wr_cond | output | 1 | PC write enable qualified by the ALU zero flag |
| mem_addr_alu | output | 1 | Memory address from the ALU result register (0: from PC) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| rf_wdata_mem | output | 1 | Register-file write data from memory data register (0: ALU result) |
| ir_wr | output | 1 | Instruction register write enable |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| alu_a_reg | output | 1 | ALU first operand from register A (0: PC) |
| alu_b_sel | output | 2 | ALU second operand: 00 register B, 01 four, 10 offset, 11 offset shifted by 2 |
| rf_wr | output | 1 | Register-file write enable |
| rf_dst_rd | output | 1 | Destination register from rd field (0: rt field) |

## Verification
Because the outputs are a pure decode of the state register, a wrong transition shows on the ports in the very next cycle. There it appears as a control pattern that does not match the expected step. A sequence that runs too long or ends too early appears as a missing or misplaced fetch pattern, with `ir_wr` high at the wrong cycle. The bench therefore compares the full 16-bit control word in every cycle of each instruction class, so every transition and every decoded line is observed. It also checks that an opcode change in the middle of a cycle leaves the word unchanged, and that the word steers the following transition only from the next edge.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

   // Sequencer steps; values are contiguous so a one-hot index maps back to them
   typedef enum logic [3:0] {
      S_FETCH  = 4'd0,
      S_DECODE = 4'd1,
      S_ADDR   = 4'd2,
      S_LDMEM  = 4'd3,
      S_LDWB   = 4'd4,
      S_STMEM  = 4'd5,
      S_REXE   = 4'd6,
      S_RWB    = 4'd7,
      S_BRDONE = 4'd8,
      S_JDONE  = 4'd9
   } mcs_state_e;

   localparam int unsigned NUM_STATES = 10;

   typedef enum logic [2:0] {
      C_LOAD,
      C_STORE,
      C_RTYPE,
      C_BEQ,
      C_JUMP,
      C_OTHER
   } mcs_class_e;

   // Datapath select encodings
   localparam logic [1:0] PCSRC_ALU    = 2'b00;
   localparam logic [1:0] PCSRC_ALUREG = 2'b01;
   localparam logic [1:0] PCSRC_JUMP   = 2'b10;

   localparam logic [1:0] ALUOP_ADD    = 2'b00;
   localparam logic [1:0] ALUOP_SUB    = 2'b01;
   localparam logic [1:0] ALUOP_FUNCT  = 2'b10;

   localparam logic [1:0] ALUB_REG     = 2'b00;
   localparam logic [1:0] ALUB_FOUR    = 2'b01;
   localparam logic [1:0] ALUB_IMM     = 2'b10;
   localparam logic [1:0] ALUB_IMMSH   = 2'b11;

   typedef struct packed {
      logic       pc_wr;
      logic       pc_wr_cond;
      logic       mem_addr_alu;
      logic       mem_rd;
      logic       mem_wr;
      logic       rf_wdata_mem;
      logic       ir_wr;
      logic [1:0] pc_src;
      logic [1:0] alu_op;
      logic       alu_a_reg;
      logic [1:0] alu_b_sel;
      logic       rf_wr;
      logic       rf_dst_rd;
   } mcs_ctl_t;

   localparam mcs_ctl_t CTL_IDLE = '0;

endpackage

// File: rtl/mcs_opclass.sv
module mcs_opclass
   import mcs_pkg::*;
#(
   parameter int unsigned     OPC_W     = 6,
   parameter logic [OPC_W-1:0] OPC_LOAD  = 6'h23,
   parameter logic [OPC_W-1:0] OPC_STORE = 6'h2B,
   parameter logic [OPC_W-1:0] OPC_RTYPE = 6'h00,
   parameter logic [OPC_W-1:0] OPC_BEQ   = 6'h04,
   parameter logic [OPC_W-1:0] OPC_JUMP  = 6'h02
) (
   input  logic [OPC_W-1:0] opcode,
   output mcs_class_e       op_class
);

   localparam int unsigned N_OPS = 5;
   localparam logic [N_OPS-1:0][OPC_W-1:0] OPS =
      {OPC_JUMP, OPC_BEQ, OPC_RTYPE, OPC_STORE, OPC_LOAD};

   // Elaboration-time checks on the parameter set
   if (OPC_W < 2) begin : g_bad_width
      $error("mcs_opclass: OPC_W must be at least 2");
   end
   for (genvar i = 0; i < N_OPS; i++) begin : g_uniq_i
      for (genvar j = i + 1; j < N_OPS; j++) begin : g_uniq_j
         if (OPS[i] == OPS[j]) begin : g_dup
            $error("mcs_opclass: two supported opcodes share a value");
         end
      end
   end

   // One match line per supported opcode
   logic [N_OPS-1:0] hit;
   for (genvar k = 0; k < N_OPS; k++) begin : g_match
      assign hit[k] = (opcode == OPS[k]);
   end

   always_comb begin
      op_class = C_OTHER;
      unique case (1'b1)
         hit[0]:  op_class = C_LOAD;
         hit[1]:  op_class = C_STORE;
         hit[2]:  op_class = C_RTYPE;
         hit[3]:  op_class = C_BEQ;
         hit[4]:  op_class = C_JUMP;
         default: op_class = C_OTHER;
      endcase
   end

endmodule

// File: rtl/mcs_next.sv
module mcs_next
   import mcs_pkg::*;
(
   input  mcs_state_e state,
   input  mcs_class_e op_class,
   output mcs_state_e nxt
);

   always_comb begin
      nxt = S_FETCH;
      unique case (state)
         S_FETCH:  nxt = S_DECODE;
         S_DECODE: begin
            unique case (op_class)
               C_LOAD, C_STORE: nxt = S_ADDR;
               C_RTYPE:         nxt = S_REXE;
               C_BEQ:           nxt = S_BRDONE;
               C_JUMP:          nxt = S_JDONE;
               default:         nxt = S_FETCH;
            endcase
         end
         S_ADDR: begin
            if (op_class == C_LOAD)       nxt = S_LDMEM;
            else if (op_class == C_STORE) nxt = S_STMEM;
            else                          nxt = S_FETCH;
         end
         S_LDMEM:  nxt = S_LDWB;
         S_REXE:   nxt = S_RWB;
         S_LDWB, S_STMEM, S_RWB, S_BRDONE, S_JDONE: nxt = S_FETCH;
         default:  nxt = S_FETCH;
      endcase
   end

endmodule

// File: rtl/mcs_state_reg.sv
module mcs_state_reg
   import mcs_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  mcs_state_e nxt,
   output mcs_state_e state
);

   if (ONE_HOT) begin : g_onehot
      logic [NUM_STATES-1:0] oh_q;

      always_ff @(posedge clk) begin
         if (rst) oh_q <= NUM_STATES'(1);
         else     oh_q <= NUM_STATES'(1) << nxt;
      end

      always_comb begin
         state = S_FETCH;
         for (int i = 0; i < NUM_STATES; i++) begin
            if (oh_q[i]) state = mcs_state_e'(4'(i));
         end
      end

      // R1
      onehot_valid_chk: assert property (@(posedge clk) disable iff (rst)
         $countones(oh_q) == 1);
   end else begin : g_binary
      mcs_state_e st_q;

      always_ff @(posedge clk) begin
         if (rst) st_q <= S_FETCH;
         else     st_q <= nxt;
      end

      assign state = st_q;
   end

endmodule

// File: rtl/mcs_outdec.sv
module mcs_outdec
   import mcs_pkg::*;
(
   input  mcs_state_e state,
   output mcs_ctl_t   ctl
);

   always_comb begin
      ctl = CTL_IDLE;
      unique case (state)
         S_FETCH: begin
            ctl.mem_rd    = 1'b1;
            ctl.ir_wr     = 1'b1;
            ctl.alu_b_sel = ALUB_FOUR;
            ctl.alu_op    = ALUOP_ADD;
            ctl.pc_src    = PCSRC_ALU;
            ctl.pc_wr     = 1'b1;
         end
         S_DECODE: begin
            ctl.alu_b_sel = ALUB_IMMSH;
            ctl.alu_op    = ALUOP_ADD;
         end
         S_ADDR: begin
            ctl.alu_a_reg = 1'b1;
            ctl.alu_b_sel = ALUB_IMM;
            ctl.alu_op    = ALUOP_ADD;
         end
         S_LDMEM: begin
            ctl.mem_rd       = 1'b1;
            ctl.mem_addr_alu = 1'b1;
         end
         S_LDWB: begin
            ctl.rf_wr        = 1'b1;
            ctl.rf_wdata_mem = 1'b1;
         end
         S_STMEM: begin
            ctl.mem_wr       = 1'b1;
            ctl.mem_addr_alu = 1'b1;
         end
         S_REXE: begin
            ctl.alu_a_reg = 1'b1;
            ctl.alu_b_sel = ALUB_REG;
            ctl.alu_op    = ALUOP_FUNCT;
         end
         S_RWB: begin
            ctl.rf_wr     = 1'b1;
            ctl.rf_dst_rd = 1'b1;
         end
         S_BRDONE: begin
            ctl.alu_a_reg  = 1'b1;
            ctl.alu_b_sel  = ALUB_REG;
            ctl.alu_op     = ALUOP_SUB;
            ctl.pc_wr_cond = 1'b1;
            ctl.pc_src     = PCSRC_ALUREG;
         end
         S_JDONE: begin
            ctl.pc_wr  = 1'b1;
            ctl.pc_src = PCSRC_JUMP;
         end
         default: ctl = CTL_IDLE;
      endcase
   end

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
   import mcs_pkg::*;
#(
   parameter int unsigned      OPC_W     = 6,
   parameter logic [OPC_W-1:0] OPC_LOAD  = 6'h23,
   parameter logic [OPC_W-1:0] OPC_STORE = 6'h2B,
   parameter logic [OPC_W-1:0] OPC_RTYPE = 6'h00,
   parameter logic [OPC_W-1:0] OPC_BEQ   = 6'h04,
   parameter logic [OPC_W-1:0] OPC_JUMP  = 6'h02,
   parameter bit               ONE_HOT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   output logic             pc_wr,
   output logic             pc_wr_cond,
   output logic             mem_addr_alu,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             rf_wdata_mem,
   output logic             ir_wr,
   output logic [1:0]       pc_src,
   output logic [1:0]       alu_op,
   output logic             alu_a_reg,
   output logic [1:0]       alu_b_sel,
   output logic             rf_wr,
   output logic             rf_dst_rd
);

   mcs_class_e op_class;
   mcs_state_e state;
   mcs_state_e nxt;
   mcs_ctl_t   ctl;

   mcs_opclass #(
      .OPC_W     (OPC_W),
      .OPC_LOAD  (OPC_LOAD),
      .OPC_STORE (OPC_STORE),
      .OPC_RTYPE (OPC_RTYPE),
      .OPC_BEQ   (OPC_BEQ),
      .OPC_JUMP  (OPC_JUMP)
   ) u_opclass (
      .opcode   (opcode),
      .op_class (op_class)
   );

   mcs_next u_next (
      .state    (state),
      .op_class (op_class),
      .nxt      (nxt)
   );

   mcs_state_reg #(
      .ONE_HOT (ONE_HOT)
   ) u_state (
      .clk   (clk),
      .rst   (rst),
      .nxt   (nxt),
      .state (state)
   );

   mcs_outdec u_outdec (
      .state (state),
      .ctl   (ctl)
   );

   assign pc_wr        = ctl.pc_wr;
   assign pc_wr_cond   = ctl.pc_wr_cond;
   assign mem_addr_alu = ctl.mem_addr_alu;
   assign mem_rd       = ctl.mem_rd;
   assign mem_wr       = ctl.mem_wr;
   assign rf_wdata_mem = ctl.rf_wdata_mem;
   assign ir_wr        = ctl.ir_wr;
   assign pc_src       = ctl.pc_src;
   assign alu_op       = ctl.alu_op;
   assign alu_a_reg    = ctl.alu_a_reg;
   assign alu_b_sel    = ctl.alu_b_sel;
   assign rf_wr        = ctl.rf_wr;
   assign rf_dst_rd    = ctl.rf_dst_rd;

   // R1
   reset_fetch_chk: assert property (@(posedge clk)
      $past(rst) |-> (ir_wr && pc_wr));

   // R3
   fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
      ir_wr |=> (alu_b_sel == ALUB_IMMSH && !ir_wr && !pc_wr));

   // R5
   load_wb_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_rd && mem_addr_alu) |=> (rf_wr && rf_wdata_mem && !rf_dst_rd));

   // R6
   store_ret_chk: assert property (@(posedge clk) disable iff (rst)
      mem_wr |=> ir_wr);

   // R7
   rtype_ret_chk: assert property (@(posedge clk) disable iff (rst)
      (rf_wr && rf_dst_rd) |=> ir_wr);

   // R8
   branch_ret_chk: assert property (@(posedge clk) disable iff (rst)
      pc_wr_cond |=> ir_wr);

   // R9
   jump_ret_chk: assert property (@(posedge clk) disable iff (rst)
      (pc_wr && pc_src == PCSRC_JUMP) |=> ir_wr);

   // R11
   mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

endmodule

// File: tb/mc_seq_ctrl_bench.sv
module mc_seq_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = 6'h00;
   logic       pc_wr, pc_wr_cond, mem_addr_alu, mem_rd, mem_wr, rf_wdata_mem, ir_wr;
   logic [1:0] pc_src, alu_op, alu_b_sel;
   logic       alu_a_reg, rf_wr, rf_dst_rd;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   mc_seq_ctrl u_mc_seq_ctrl (
      .clk, .rst, .opcode, .pc_wr, .pc_wr_cond, .mem_addr_alu, .mem_rd,
      .mem_wr, .rf_wdata_mem, .ir_wr, .pc_src, .alu_op, .alu_a_reg,
      .alu_b_sel, .rf_wr, .rf_dst_rd
   );

   // Observed word: {pc_wr, pc_wr_cond, mem_addr_alu, mem_rd, mem_wr,
   //  rf_wdata_mem, ir_wr, pc_src[1:0], alu_op[1:0], alu_a_reg,
   //  alu_b_sel[1:0], rf_wr, rf_dst_rd}
   wire [15:0] obs = {pc_wr, pc_wr_cond, mem_addr_alu, mem_rd, mem_wr,
                      rf_wdata_mem, ir_wr, pc_src, alu_op, alu_a_reg,
                      alu_b_sel, rf_wr, rf_dst_rd};

   localparam logic [15:0] E_FETCH = {7'b1001001, 2'b00, 2'b00, 1'b0, 2'b01, 2'b00};
   localparam logic [15:0] E_DEC   = {7'b0000000, 2'b00, 2'b00, 1'b0, 2'b11, 2'b00};
   localparam logic [15:0] E_ADDR  = {7'b0000000, 2'b00, 2'b00, 1'b1, 2'b10, 2'b00};
   localparam logic [15:0] E_LDMEM = {7'b0011000, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00};
   localparam logic [15:0] E_LDWB  = {7'b0000010, 2'b00, 2'b00, 1'b0, 2'b00, 2'b10};
   localparam logic [15:0] E_STMEM = {7'b0010100, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00};
   localparam logic [15:0] E_REXE  = {7'b0000000, 2'b00, 2'b10, 1'b1, 2'b00, 2'b00};
   localparam logic [15:0] E_RWB   = {7'b0000000, 2'b00, 2'b00, 1'b0, 2'b00, 2'b11};
   localparam logic [15:0] E_BR    = {7'b0100000, 2'b01, 2'b01, 1'b1, 2'b00, 2'b00};
   localparam logic [15:0] E_JMP   = {7'b1000000, 2'b10, 2'b00, 1'b0, 2'b00, 2'b00};
   localparam logic [15:0] E_NONE  = 16'h0000;

   typedef struct packed {
      logic [15:0]       tag;
      logic [5:0]        opc;
      logic [2:0]        len;
      logic [4:0][15:0]  exp;   // exp[0] is the fetch cycle
   } vec_t;

   localparam int N_VEC = 10;
   localparam vec_t VECS [N_VEC] = '{
      '{"R5",  6'h23, 3'd5, {E_LDWB, E_LDMEM, E_ADDR, E_DEC, E_FETCH}},
      '{"R6",  6'h2B, 3'd4, {E_NONE, E_STMEM, E_ADDR, E_DEC, E_FETCH}},
      '{"R7",  6'h00, 3'd4, {E_NONE, E_RWB,   E_REXE, E_DEC, E_FETCH}},
      '{"R8",  6'h04, 3'd3, {E_NONE, E_NONE,  E_BR,   E_DEC, E_FETCH}},
      '{"R9",  6'h02, 3'd3, {E_NONE, E_NONE,  E_JMP,  E_DEC, E_FETCH}},
      '{"R10", 6'h3F, 3'd2, {E_NONE, E_NONE,  E_NONE, E_DEC, E_FETCH}},
      '{"R4",  6'h23, 3'd5, {E_LDWB, E_LDMEM, E_ADDR, E_DEC, E_FETCH}},
      '{"R8",  6'h04, 3'd3, {E_NONE, E_NONE,  E_BR,   E_DEC, E_FETCH}},
      '{"R3",  6'h00, 3'd4, {E_NONE, E_RWB,   E_REXE, E_DEC, E_FETCH}},
      '{"R10", 6'h08, 3'd2, {E_NONE, E_NONE,  E_NONE, E_DEC, E_FETCH}}
   };

   task automatic check(input string tag, input logic [15:0] exp);
      checks++;
      if (obs !== exp) begin
         fails++;
         $display("FAIL %s at %0t: got %b expected %b", tag, $time, obs, exp);
      end
   endtask

   initial begin
      // R1: reset state while held in reset
      repeat (2) @(negedge clk);
      check("R1", E_FETCH);
      rst = 1'b0;

      // R2..R10: table walk; each vector starts at a fetch-cycle negedge
      for (int v = 0; v < N_VEC; v++) begin
         opcode = VECS[v].opc;
         for (int k = 0; k < int'(VECS[v].len); k++) begin
            check((k == 0) ? "R2" : string'(VECS[v].tag), VECS[v].exp[k]);
            @(negedge clk);
         end
      end
      check("R2", E_FETCH);

      // R11: opcode change inside decode leaves outputs; it steers the next edge
      opcode = 6'h23;
      @(negedge clk);
      check("R11", E_DEC);
      opcode = 6'h04;
      #1 check("R11", E_DEC);
      @(negedge clk);
      check("R8", E_BR);
      @(negedge clk);
      check("R8", E_FETCH);

      // R10: opcode leaves load/store class during address formation
      opcode = 6'h2B;
      repeat (2) @(negedge clk);
      check("R4", E_ADDR);
      opcode = 6'h02;
      @(negedge clk);
      check("R10", E_FETCH);

      // R1: reset in the middle of a load
      opcode = 6'h23;
      repeat (3) @(negedge clk);
      check("R5", E_LDMEM);
      rst = 1'b1;
      @(negedge clk);
      check("R1", E_FETCH);
      @(negedge clk);
      check("R1", E_FETCH);
      rst = 1'b0;
      @(negedge clk);
      check("R1", E_DEC);
      @(negedge clk);
      check("R4", E_ADDR);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule